// File: doc/BRIEF.md
# Speculation Tag Consistency Monitor

This block watches the in-flight bookkeeping of an out-of-order core and flags states that break the ordering between a committed main sequence and a transient sequence. A boundary ROB ID splits the circular reorder buffer into two sets. IDs from the head up to and including the boundary are committable. Every other ID is transient, or uncommittable. Each bookkeeping slot carries a valid bit, a ROB ID and a speculation mask. The monitor reduces the masks of the transient slots with AND and the masks of the committable slots with OR. It then tests the results against the spawn tag of the boundary instruction and against the spawn tags of resolving branches.

The monitor also checks two rules about the boundary misprediction. Until the misprediction, the tail pointer must point into the transient set. In the cycle after the misprediction, no transient ROB entry may still be valid. Each rule has its own sticky flag, and the flags are also ORed into one alarm. The block is meant to sit beside a core model or in a formal harness as a passive observer.

Top module: `spec_tag_monitor`

## Requirements
- R1: Let d(x) = (x - head) mod ROB_DEPTH. A ROB ID `id` is committable exactly when d(id) <= d(boundary). All other IDs are uncommittable. Both pointers wrap around at ROB_DEPTH (64).
- R2: Before the first boundary misprediction, `viol_tag_and` is set one cycle after any cycle in which (U & `root_spawn`) != `root_spawn`. Here U is the AND of the masks of the valid uncommittable slots, and U is all ones when there are none.
- R3: Invalid slots and committable slots never take part in the AND reduction of R2.
- R4: Before the first boundary misprediction, `viol_spawn` is set one cycle after a cycle in which a valid resolution port has an uncommittable ROB ID and a spawn tag that overlaps C. C is the OR of the masks of the valid committable slots. Invalid slots, uncommittable slots and invalid ports never contribute.
- R5: Before the first boundary misprediction, `viol_tail` is set one cycle after a cycle in which `rob_tail` is committable. The cycle in which `root_mispredict` is high is still checked.
- R6: In the cycle after `root_mispredict` is high, any bit `i` of `rob_valid` that is set with `i` uncommittable sets `viol_flush` one cycle later.
- R7: After reset all flags are 0. A flag that is set stays set until reset.
- R8: `alarm` is the OR of the four flags.
- R9: After the cycle in which `root_mispredict` is seen, the R2, R4 and R5 checks no longer set any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rob_head | input | 6 | ROB head pointer |
| rob_tail | input | 6 | ROB tail pointer |
| root_id | input | 6 | Boundary ROB ID (last main-sequence instruction) |
| root_spawn | input | 12 | Spawn tag of the boundary instruction |
| root_mispredict | input | 1 | Misprediction of the boundary instruction signalled |
| rob_valid | input | 64 | Valid bit per ROB entry, bit i is ROB ID i |
| slot_valid | input | 8 | Valid bit per bookkeeping slot |
| slot_rob_id | input | 48 | ROB ID per slot, slot k in bits [6k+5:6k] |
| slot_mask | input | 96 | Speculation mask per slot, slot k in bits [12k+11:12k] |
| res_valid | input | 2 | Branch resolution valid per port |
| res_rob_id | input | 12 | ROB ID per resolution port, port p in bits [6p+5:6p] |
| res_spawn | input | 24 | Spawn tag per resolution port, port p in bits [12p+11:12p] |
| viol_tag_and | output | 1 | Sticky flag for R2 |
| viol_spawn | output | 1 | Sticky flag for R4 |
| viol_tail | output | 1 | Sticky flag for R5 |
| viol_flush | output | 1 | Sticky flag for R6 |
| alarm | output | 1 | OR of all flags |

## Verification
The properties assume that the head, boundary and tail pointers keep their meaning from cycle to cycle. They also assume that `root_mispredict` is a pulse that marks the end of the speculative window, so the first pulse after reset is the one that counts. The properties do not depend on the contents of the slots, so any mask or ID pattern is legal. The stimulus resets the block before every scenario and pulses the misprediction at most once within it. Random slot, port and pointer values are mixed with directed cases for wraparound, a boundary equal to the head, an empty transient set and ignored invalid entries.

// File: rtl/spec_tag_monitor.sv
module spec_tag_monitor #(
  parameter int ROB_DEPTH = 64,
  parameter int TAG_W     = 12,
  parameter int NSLOT     = 8,
  parameter int NRES      = 2,
  localparam int ID_W     = $clog2(ROB_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ID_W-1:0]        rob_head,
  input  logic [ID_W-1:0]        rob_tail,
  input  logic [ID_W-1:0]        root_id,
  input  logic [TAG_W-1:0]       root_spawn,
  input  logic                   root_mispredict,
  input  logic [ROB_DEPTH-1:0]   rob_valid,
  input  logic [NSLOT-1:0]       slot_valid,
  input  logic [NSLOT*ID_W-1:0]  slot_rob_id,
  input  logic [NSLOT*TAG_W-1:0] slot_mask,
  input  logic [NRES-1:0]        res_valid,
  input  logic [NRES*ID_W-1:0]   res_rob_id,
  input  logic [NRES*TAG_W-1:0]  res_spawn,
  output logic                   viol_tag_and,
  output logic                   viol_spawn,
  output logic                   viol_tail,
  output logic                   viol_flush,
  output logic                   alarm
);

  function automatic logic is_commit(input logic [ID_W-1:0] id, input logic [ID_W-1:0] head,
                                     input logic [ID_W-1:0] root);
    logic [ID_W-1:0] d_id, d_root;
    d_id   = id - head;
    d_root = root - head;
    return d_id <= d_root;
  endfunction

  logic [TAG_W-1:0] unc_and, com_or;
  logic             res_bad, flush_bad;
  logic             seen_mp, mp_d;

  always_comb begin
    unc_and = '1;
    com_or  = '0;
    for (int k = 0; k < NSLOT; k++) begin
      if (slot_valid[k]) begin
        if (is_commit(slot_rob_id[k*ID_W +: ID_W], rob_head, root_id))
          com_or  = com_or | slot_mask[k*TAG_W +: TAG_W];
        else
          unc_and = unc_and & slot_mask[k*TAG_W +: TAG_W];
      end
    end
  end

  always_comb begin
    res_bad = 1'b0;
    for (int p = 0; p < NRES; p++)
      if (res_valid[p] && !is_commit(res_rob_id[p*ID_W +: ID_W], rob_head, root_id) &&
          ((res_spawn[p*TAG_W +: TAG_W] & com_or) != '0))
        res_bad = 1'b1;
  end

  always_comb begin
    flush_bad = 1'b0;
    for (int i = 0; i < ROB_DEPTH; i++)
      if (rob_valid[i] && !is_commit(ID_W'(i), rob_head, root_id))
        flush_bad = 1'b1;
  end

  wire tag_bad  = (unc_and & root_spawn) != root_spawn;
  wire tail_bad = is_commit(rob_tail, rob_head, root_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_mp      <= 1'b0;
      mp_d         <= 1'b0;
      viol_tag_and <= 1'b0;
      viol_spawn   <= 1'b0;
      viol_tail    <= 1'b0;
      viol_flush   <= 1'b0;
    end else begin
      seen_mp <= seen_mp | root_mispredict;
      mp_d    <= root_mispredict;
      if (!seen_mp) begin
        viol_tag_and <= viol_tag_and | tag_bad;
        viol_spawn   <= viol_spawn | res_bad;
        viol_tail    <= viol_tail | tail_bad;
      end
      viol_flush <= viol_flush | (mp_d & flush_bad);
    end
  end

  assign alarm = viol_tag_and | viol_spawn | viol_tail | viol_flush;

endmodule

// File: rtl/spec_tag_monitor_chk.sv
module spec_tag_monitor_chk #(
  parameter int ROB_DEPTH = 64,
  parameter int TAG_W     = 12,
  parameter int NSLOT     = 8,
  parameter int NRES      = 2,
  localparam int ID_W     = $clog2(ROB_DEPTH)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ID_W-1:0]        rob_head,
  input logic [ID_W-1:0]        rob_tail,
  input logic [ID_W-1:0]        root_id,
  input logic                   root_mispredict,
  input logic [ROB_DEPTH-1:0]   rob_valid,
  input logic                   viol_tag_and,
  input logic                   viol_spawn,
  input logic                   viol_tail,
  input logic                   viol_flush,
  input logic                   alarm
);

  logic ck_seen, ck_mp;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_seen <= 1'b0;
      ck_mp   <= 1'b0;
    end else begin
      ck_seen <= ck_seen | root_mispredict;
      ck_mp   <= root_mispredict;
    end

  logic [ID_W-1:0] dt, dr;
  logic            stale;
  always_comb begin
    dr    = root_id - rob_head;
    dt    = rob_tail - rob_head;
    stale = 1'b0;
    for (int i = 0; i < ROB_DEPTH; i++)
      if (rob_valid[i] && (ID_W'(ID_W'(i) - rob_head) > dr)) stale = 1'b1;
  end

  wire [3:0] flags = {viol_tag_and, viol_spawn, viol_tail, viol_flush};

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != 4'd0) |=> ((flags & $past(flags)) == $past(flags)));

  assert_alarm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm);

  assert_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_seen && dt <= dr) |=> viol_tail);

  assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_mp && stale) |=> viol_flush);

  assert_quiet_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_seen && !viol_tail) |=> !viol_tail);

endmodule

bind spec_tag_monitor spec_tag_monitor_chk #(
  .ROB_DEPTH(ROB_DEPTH), .TAG_W(TAG_W), .NSLOT(NSLOT), .NRES(NRES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .rob_head(rob_head), .rob_tail(rob_tail),
  .root_id(root_id), .root_mispredict(root_mispredict), .rob_valid(rob_valid),
  .viol_tag_and(viol_tag_and), .viol_spawn(viol_spawn), .viol_tail(viol_tail),
  .viol_flush(viol_flush), .alarm(alarm)
);

// File: tb/test_spec_tag_monitor.sv
`timescale 1ns/1ps
module test_spec_tag_monitor;
  localparam int DEPTH = 64, TW = 12, NS = 8, NR = 2, IW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IW-1:0] rob_head, rob_tail, root_id;
  logic [TW-1:0] root_spawn;
  logic root_mispredict;
  logic [DEPTH-1:0] rob_valid;
  logic [NS-1:0] slot_valid;
  logic [NS*IW-1:0] slot_rob_id;
  logic [NS*TW-1:0] slot_mask;
  logic [NR-1:0] res_valid;
  logic [NR*IW-1:0] res_rob_id;
  logic [NR*TW-1:0] res_spawn;
  logic viol_tag_and, viol_spawn, viol_tail, viol_flush, alarm;

  always #2.5 clk = ~clk;

  spec_tag_monitor i_spec_tag_monitor (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic eA, eB, eT, eF, bseen, bmp;

  function automatic bit cm(input logic [IW-1:0] id);
    logic [IW-1:0] a, b;
    a = id - rob_head;
    b = root_id - rob_head;
    return a <= b;
  endfunction

  function automatic bit want_a();
    logic [TW-1:0] u = '1;
    for (int k = 0; k < NS; k++)
      if (slot_valid[k] && !cm(slot_rob_id[k*IW +: IW])) u &= slot_mask[k*TW +: TW];
    return (u & root_spawn) != root_spawn;
  endfunction

  function automatic bit want_b();
    logic [TW-1:0] c = '0;
    bit r = 0;
    for (int k = 0; k < NS; k++)
      if (slot_valid[k] && cm(slot_rob_id[k*IW +: IW])) c |= slot_mask[k*TW +: TW];
    for (int p = 0; p < NR; p++)
      if (res_valid[p] && !cm(res_rob_id[p*IW +: IW]) && ((res_spawn[p*TW +: TW] & c) != 0)) r = 1;
    return r;
  endfunction

  function automatic bit want_f();
    bit r = 0;
    for (int i = 0; i < DEPTH; i++) if (rob_valid[i] && !cm(IW'(i))) r = 1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    if (!bseen) begin
      eA |= want_a();
      eB |= want_b();
      eT |= cm(rob_tail);
    end
    eF |= bmp & want_f();
    bseen |= root_mispredict;
    bmp = root_mispredict;
    @(negedge clk);
    chk("R2/R3 viol_tag_and", viol_tag_and, eA);
    chk("R4 viol_spawn", viol_spawn, eB);
    chk("R1/R5/R9 viol_tail", viol_tail, eT);
    chk("R6 viol_flush", viol_flush, eF);
    chk("R8 alarm", alarm, eA | eB | eT | eF);
  endtask

  task automatic quiet();
    rob_head = 6'd0; root_id = 6'd10; rob_tail = 6'd20;
    root_spawn = 12'h001; root_mispredict = 0; rob_valid = '0;
    slot_valid = '0; slot_rob_id = '0; slot_mask = '0;
    res_valid = '0; res_rob_id = '0; res_spawn = '0;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    {eA, eB, eT, eF, bseen, bmp} = '0;
    chk("R7 reset viol_tag_and", viol_tag_and, 1'b0);
    chk("R7 reset alarm", alarm, 1'b0);
  endtask

  task automatic randomize_inputs();
    rob_head = IW'($urandom); root_id = IW'($urandom); rob_tail = IW'($urandom);
    root_spawn = TW'(1) << ($urandom % TW);
    rob_valid = {$urandom, $urandom};
    slot_valid = NS'($urandom);
    for (int k = 0; k < NS; k++) begin
      slot_rob_id[k*IW +: IW] = IW'($urandom);
      slot_mask[k*TW +: TW] = ($urandom % 2) ? (TW'($urandom) | root_spawn) : TW'($urandom);
    end
    res_valid = NR'($urandom);
    for (int p = 0; p < NR; p++) begin
      res_rob_id[p*IW +: IW] = IW'($urandom);
      res_spawn[p*TW +: TW] = TW'(1) << ($urandom % TW);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1 wraparound: head 60, boundary 3, tail 2 is committable
    do_reset();
    rob_head = 6'd60; root_id = 6'd3; rob_tail = 6'd2;
    step();
    // R1 wraparound: tail 4 uncommittable, no flag
    do_reset();
    rob_head = 6'd60; root_id = 6'd3; rob_tail = 6'd4;
    step();
    // R1 boundary equals head: only head committable
    do_reset();
    rob_head = 6'd7; root_id = 6'd7; rob_tail = 6'd8;
    slot_valid = 8'h01; slot_rob_id[0 +: IW] = 6'd8; slot_mask[0 +: TW] = 12'h000;
    root_spawn = 12'h004;
    step();
    // R3 empty transient set, invalid slot with bad mask ignored
    do_reset();
    slot_valid = 8'h01; slot_rob_id[0 +: IW] = 6'd5; slot_mask[0 +: TW] = 12'h000;
    slot_rob_id[IW +: IW] = 6'd30; slot_mask[TW +: TW] = 12'h000;
    step();
    // R4 invalid port ignored, then valid port overlaps
    do_reset();
    slot_valid = 8'h01; slot_rob_id[0 +: IW] = 6'd2; slot_mask[0 +: TW] = 12'h010;
    res_valid = 2'b00; res_rob_id = {6'd40, 6'd40}; res_spawn = {12'h010, 12'h010};
    step();
    res_valid = 2'b10;
    step();
    // R7 sticky with benign inputs
    quiet();
    step();
    // R6 / R9 mispredict sequence
    do_reset();
    root_mispredict = 1; rob_valid = 64'h0000_0000_0000_0400;
    step();
    root_mispredict = 0; rob_valid = 64'h0000_0000_0000_0800; rob_tail = 6'd3;
    step();
    quiet(); rob_tail = 6'd1; root_spawn = 12'hfff;
    slot_valid = 8'h01; slot_rob_id[0 +: IW] = 6'd40;
    step();
    // R6 flush with only committable entries valid
    do_reset();
    root_mispredict = 1;
    step();
    root_mispredict = 0; rob_valid = 64'h0000_0000_0000_07ff;
    step();
    // random scenarios
    for (int t = 0; t < 300; t++) begin
      do_reset();
      randomize_inputs();
      root_mispredict = 0;
      step();
      randomize_inputs();
      root_mispredict = ($urandom % 3) == 0;
      step();
      randomize_inputs();
      root_mispredict = 0;
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule